// File: doc/BRIEF.md
# Routing Switch Box

This block models one crossing of the routing fabric in a programmable logic array, where horizontal and vertical tracks meet. Each of the four sides (north, east, south, west) brings eight single-length tracks and four double-length tracks to the crossing.

Every track index forms one interconnect point with six switches, one for each pair of sides. A signal arriving on one side can leave on any mix of the other three sides, so one net can branch to several sides. A bidirectional pass-transistor node is modelled with a separate input, output, valid flag and drive enable for each side of each track. Each point also has a flag that is raised when two drivers meet.

The switch settings are shifted in one bit per clock. They reach the fabric only when a load strobe is given, so the routing does not change while a new setting is being shifted. The path from inputs to outputs is purely combinational. Only the configuration store is clocked.

Top module: `rsb_switch_box`

## Requirements
- R1: After a synchronous reset, every switch is off and every output reads 0 with its valid flag low, and every contention flag is low, whatever the inputs and drive enables.
- R2: Shifting configuration bits while no load strobe is given leaves the routing behaviour unchanged.
- R3: A load strobe copies the shift chain into the active switch settings on that clock edge. The chain shifts toward higher bit positions, so after 72 shifts the first bit sent sits in bit 71 and the last bit sent in bit 0.
- R4: A switch is symmetric. Suppose it joins two sides and only one of them has its drive enable set. The other side's output then equals the driving side's input, and that output's valid flag is high.
- R5: One driving side can reach two or all three other sides of the same point at once, each carrying the driver's input value with its valid flag high.
- R6: An output that has no switch path to exactly one driving side reads 0 with its valid flag low.
- R7: If two or more sides that are joined by enabled switches, directly or through other sides, all have their drive enable set, the point's contention flag goes high. All four outputs of that point then read 0 with their valid flags low.
- R8: Single-length and double-length tracks never connect. Settings and drive on one type never affect outputs of the other type.
- R9: Switches chain within a point. With north-east and east-south on and north driving, south receives north's input.
- R10: A side whose drive enable is set never shows a valid flag on its own output.
- R11: Configuration layout. Single track t is point t, and double track t is point 8+t. Point p uses bits 6p to 6p+5, with bit offset 0 = N-E, 1 = N-S, 2 = N-W, 3 = E-S, 4 = E-W, 5 = S-W. On the buses, side N=0, E=1, S=2, W=3, and side s of track t is bus bit s*TRK+t, where TRK is 8 for single tracks and 4 for double tracks.
- R12: Track index i on one side connects only to track index i on the other sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift | input | 1 | Shift one configuration bit in this cycle |
| cfg_din | input | 1 | Serial configuration bit |
| cfg_load | input | 1 | Copy the shift chain into the active settings |
| sgl_in | input | 32 | Single-track side inputs, bit s*8+t |
| sgl_drv | input | 32 | Single-track drive enables, bit s*8+t |
| sgl_out | output | 32 | Single-track side outputs |
| sgl_vld | output | 32 | Single-track output valid flags |
| sgl_clash | output | 8 | Contention flag per single track |
| dbl_in | input | 16 | Double-track side inputs, bit s*4+t |
| dbl_drv | input | 16 | Double-track drive enables, bit s*4+t |
| dbl_out | output | 16 | Double-track side outputs |
| dbl_vld | output | 16 | Double-track output valid flags |
| dbl_clash | output | 4 | Contention flag per double track |

## Verification
A wrong bit in the active settings shows at once, through combinational logic, as a wrong valid flag or a leaked value on the affected point. It is exposed as soon as a drive pattern reaches the pair that bit controls. This is why the bench steps through all 64 switch settings of every point against all 16 drive patterns. A misordered or lost bit in the shift chain does not show until the next load strobe. After that strobe it shifts settings between points or between switch pairs, and the bench compares all 12 points after each load. A fault in the connected-group logic shows as a wrong contention flag or a missing chained route, only under patterns with two or more enabled switches.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    localparam int SIDES    = 4;
    localparam int PAIRS    = 6;
    localparam int SGL_TRKS = 8;
    localparam int DBL_TRKS = 4;

    typedef enum logic [1:0] {
        SIDE_N = 2'd0,
        SIDE_E = 2'd1,
        SIDE_S = 2'd2,
        SIDE_W = 2'd3
    } side_e;

    typedef logic [PAIRS-1:0]            sw_t;
    typedef logic [SIDES-1:0]            side_vec_t;
    typedef logic [SIDES-1:0][SIDES-1:0] reach_t;

    typedef struct packed {
        side_vec_t val;
        side_vec_t vld;
        logic      clash;
    } pt_result_t;

    // Lower side of switch pair k (pair order: NE, NS, NW, ES, EW, SW)
    function automatic side_e pair_lo(input int k);
        case (k)
            0, 1, 2: return SIDE_N;
            3, 4:    return SIDE_E;
            default: return SIDE_S;
        endcase
    endfunction

    function automatic side_e pair_hi(input int k);
        case (k)
            0:       return SIDE_E;
            1, 3:    return SIDE_S;
            default: return SIDE_W;
        endcase
    endfunction

    // Which sides share a connected group through enabled switches
    function automatic reach_t sw_closure(input sw_t sw);
        reach_t r;
        reach_t n;
        r = '0;
        for (int i = 0; i < SIDES; i++) r[i][i] = 1'b1;
        for (int k = 0; k < PAIRS; k++) begin
            if (sw[k]) begin
                r[pair_lo(k)][pair_hi(k)] = 1'b1;
                r[pair_hi(k)][pair_lo(k)] = 1'b1;
            end
        end
        for (int pass = 0; pass < 2; pass++) begin
            n = r;
            for (int i = 0; i < SIDES; i++)
                for (int j = 0; j < SIDES; j++)
                    for (int m = 0; m < SIDES; m++)
                        if (r[i][m] && r[m][j]) n[i][j] = 1'b1;
            r = n;
        end
        return r;
    endfunction

    function automatic logic [2:0] count4(input side_vec_t v);
        logic [2:0] c;
        c = '0;
        for (int i = 0; i < SIDES; i++) c = c + {2'b00, v[i]};
        return c;
    endfunction

endpackage

// File: rtl/rsb_cfg_chain.sv
module rsb_cfg_chain #(
    parameter int CFG_W = 72
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             bit_in,
    input  logic             load_en,
    output logic [CFG_W-1:0] active
);

    logic [CFG_W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '0;
            active <= '0;
        end else begin
            if (shift_en) chain <= {chain[CFG_W-2:0], bit_in};
            if (load_en)  active <= chain;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (active == '0)); // R1

    AST_HOLD_CFG: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(active)); // R2

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (active == $past(chain))); // R3

endmodule

// File: rtl/rsb_point.sv
module rsb_point
    import rsb_pkg::*;
(
    input  sw_t        sw,
    input  side_vec_t  pin,
    input  side_vec_t  pdrv,
    output pt_result_t res
);

    reach_t    reach;
    side_vec_t grp [SIDES];
    logic      clash;

    always_comb begin
        reach = sw_closure(sw);
        clash = 1'b0;
        for (int s = 0; s < SIDES; s++) begin
            grp[s] = pdrv & reach[s];
            if (count4(grp[s]) >= 3'd2) clash = 1'b1;
        end
    end

    always_comb begin
        res.clash = clash;
        for (int s = 0; s < SIDES; s++) begin
            res.vld[s] = !clash && (count4(grp[s]) == 3'd1) && !pdrv[s];
            res.val[s] = res.vld[s] && |(grp[s] & pin);
        end
    end

endmodule

// File: rtl/rsb_plane.sv
module rsb_plane
    import rsb_pkg::*;
#(
    parameter int NTRK = 8
) (
    input  logic [NTRK*PAIRS-1:0] sw_cfg,
    input  logic [SIDES*NTRK-1:0] bus_in,
    input  logic [SIDES*NTRK-1:0] bus_drv,
    output logic [SIDES*NTRK-1:0] bus_out,
    output logic [SIDES*NTRK-1:0] bus_vld,
    output logic [NTRK-1:0]       clash
);

    for (genvar t = 0; t < NTRK; t++) begin : g_trk
        side_vec_t  pi;
        side_vec_t  pd;
        pt_result_t pr;

        for (genvar s = 0; s < SIDES; s++) begin : g_side
            assign pi[s]             = bus_in[s*NTRK+t];
            assign pd[s]             = bus_drv[s*NTRK+t];
            assign bus_out[s*NTRK+t] = pr.val[s];
            assign bus_vld[s*NTRK+t] = pr.vld[s];
        end

        rsb_point u_pt (
            .sw  (sw_cfg[t*PAIRS +: PAIRS]),
            .pin (pi),
            .pdrv(pd),
            .res (pr)
        );

        assign clash[t] = pr.clash;
    end

endmodule

// File: rtl/rsb_switch_box.sv
module rsb_switch_box
    import rsb_pkg::*;
#(
    parameter int SGL_TRK = SGL_TRKS,
    parameter int DBL_TRK = DBL_TRKS
) (
    input  logic                     cfg_clk,
    input  logic                     rst,
    input  logic                     cfg_shift,
    input  logic                     cfg_din,
    input  logic                     cfg_load,
    input  logic [SIDES*SGL_TRK-1:0] sgl_in,
    input  logic [SIDES*SGL_TRK-1:0] sgl_drv,
    output logic [SIDES*SGL_TRK-1:0] sgl_out,
    output logic [SIDES*SGL_TRK-1:0] sgl_vld,
    output logic [SGL_TRK-1:0]       sgl_clash,
    input  logic [SIDES*DBL_TRK-1:0] dbl_in,
    input  logic [SIDES*DBL_TRK-1:0] dbl_drv,
    output logic [SIDES*DBL_TRK-1:0] dbl_out,
    output logic [SIDES*DBL_TRK-1:0] dbl_vld,
    output logic [DBL_TRK-1:0]       dbl_clash
);

    localparam int SGL_CW = SGL_TRK * PAIRS;
    localparam int DBL_CW = DBL_TRK * PAIRS;
    localparam int CFG_W  = SGL_CW + DBL_CW;

    logic [CFG_W-1:0] active;

    rsb_cfg_chain #(.CFG_W(CFG_W)) u_cfg (
        .clk     (cfg_clk),
        .rst     (rst),
        .shift_en(cfg_shift),
        .bit_in  (cfg_din),
        .load_en (cfg_load),
        .active  (active)
    );

    rsb_plane #(.NTRK(SGL_TRK)) u_sgl (
        .sw_cfg (active[SGL_CW-1:0]),
        .bus_in (sgl_in),
        .bus_drv(sgl_drv),
        .bus_out(sgl_out),
        .bus_vld(sgl_vld),
        .clash  (sgl_clash)
    );

    rsb_plane #(.NTRK(DBL_TRK)) u_dbl (
        .sw_cfg (active[CFG_W-1:SGL_CW]),
        .bus_in (dbl_in),
        .bus_drv(dbl_drv),
        .bus_out(dbl_out),
        .bus_vld(dbl_vld),
        .clash  (dbl_clash)
    );

    AST_UNDRIVEN_LOW: assert property (@(posedge cfg_clk) disable iff (rst)
        ((sgl_out & ~sgl_vld) == '0) && ((dbl_out & ~dbl_vld) == '0)); // R6

    AST_DRIVER_SILENT: assert property (@(posedge cfg_clk) disable iff (rst)
        ((sgl_drv & sgl_vld) == '0) && ((dbl_drv & dbl_vld) == '0)); // R10

    for (genvar t = 0; t < SGL_TRK; t++) begin : g_sgl_chk
        side_vec_t sv;
        for (genvar s = 0; s < SIDES; s++) begin : g_s
            assign sv[s] = sgl_vld[s*SGL_TRK+t];
        end
        AST_CLASH_QUIET: assert property (@(posedge cfg_clk) disable iff (rst)
            sgl_clash[t] |-> (sv == '0)); // R7
    end

    for (genvar t = 0; t < DBL_TRK; t++) begin : g_dbl_chk
        side_vec_t dv;
        for (genvar s = 0; s < SIDES; s++) begin : g_s
            assign dv[s] = dbl_vld[s*DBL_TRK+t];
        end
        AST_CLASH_QUIET: assert property (@(posedge cfg_clk) disable iff (rst)
            dbl_clash[t] |-> (dv == '0)); // R7
    end

endmodule

// File: tb/rsb_switch_box_test.sv
module rsb_switch_box_test;

    localparam int NS  = 8;
    localparam int ND  = 4;
    localparam int NP  = NS + ND;
    localparam int CW  = NP * 6;

    logic cfg_clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_shift = 1'b0;
    logic cfg_din = 1'b0;
    logic cfg_load = 1'b0;
    logic [4*NS-1:0] sgl_in = '0;
    logic [4*NS-1:0] sgl_drv = '0;
    logic [4*ND-1:0] dbl_in = '0;
    logic [4*ND-1:0] dbl_drv = '0;
    wire  [4*NS-1:0] sgl_out;
    wire  [4*NS-1:0] sgl_vld;
    wire  [NS-1:0]   sgl_clash;
    wire  [4*ND-1:0] dbl_out;
    wire  [4*ND-1:0] dbl_vld;
    wire  [ND-1:0]   dbl_clash;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [CW-1:0] cfg_cur = '0;

    always #10 cfg_clk = ~cfg_clk;

    rsb_switch_box uut (
        .cfg_clk(cfg_clk), .rst(rst), .cfg_shift(cfg_shift), .cfg_din(cfg_din),
        .cfg_load(cfg_load),
        .sgl_in(sgl_in), .sgl_drv(sgl_drv), .sgl_out(sgl_out), .sgl_vld(sgl_vld),
        .sgl_clash(sgl_clash),
        .dbl_in(dbl_in), .dbl_drv(dbl_drv), .dbl_out(dbl_out), .dbl_vld(dbl_vld),
        .dbl_clash(dbl_clash)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic shift_cfg(input logic [CW-1:0] v);
        for (int i = CW - 1; i >= 0; i--) begin
            @(negedge cfg_clk);
            cfg_shift = 1'b1;
            cfg_din   = v[i];
        end
        @(negedge cfg_clk);
        cfg_shift = 1'b0;
    endtask

    task automatic pulse_load(input logic [CW-1:0] v);
        cfg_load = 1'b1;
        @(negedge cfg_clk);
        cfg_load = 1'b0;
        cfg_cur  = v;
    endtask

    // Group labelling by repeated minimum merge across enabled pairs
    task automatic model(input logic [5:0] sw, input logic [3:0] pin, input logic [3:0] drv,
                         output logic [3:0] eo, output logic [3:0] ev, output logic ec);
        int lab [4];
        int pa [6] = '{0, 0, 0, 1, 1, 2};
        int pb [6] = '{1, 2, 3, 2, 3, 3};
        int cnt [4];
        int src [4];
        for (int s = 0; s < 4; s++) lab[s] = s;
        for (int rep = 0; rep < 3; rep++)
            for (int k = 0; k < 6; k++)
                if (sw[k]) begin
                    int m;
                    m = (lab[pa[k]] < lab[pb[k]]) ? lab[pa[k]] : lab[pb[k]];
                    lab[pa[k]] = m;
                    lab[pb[k]] = m;
                end
        ec = 1'b0;
        for (int s = 0; s < 4; s++) begin
            cnt[s] = 0;
            src[s] = 0;
            for (int t = 0; t < 4; t++)
                if (lab[t] == lab[s] && drv[t]) begin
                    cnt[s]++;
                    src[s] = t;
                end
            if (cnt[s] >= 2) ec = 1'b1;
        end
        for (int s = 0; s < 4; s++) begin
            ev[s] = !ec && cnt[s] == 1 && !drv[s];
            eo[s] = ev[s] ? pin[src[s]] : 1'b0;
        end
    endtask

    // Compare every point against the model; forced tag names the requirement
    task automatic compare_all(input string forced);
        for (int p = 0; p < NP; p++) begin
            logic [3:0] pin, drv, ao, av, eo, ev;
            logic ac, ec;
            string tag;
            for (int s = 0; s < 4; s++) begin
                if (p < NS) begin
                    pin[s] = sgl_in[s*NS+p];  drv[s] = sgl_drv[s*NS+p];
                    ao[s]  = sgl_out[s*NS+p]; av[s]  = sgl_vld[s*NS+p];
                end else begin
                    pin[s] = dbl_in[s*ND+p-NS];  drv[s] = dbl_drv[s*ND+p-NS];
                    ao[s]  = dbl_out[s*ND+p-NS]; av[s]  = dbl_vld[s*ND+p-NS];
                end
            end
            ac = (p < NS) ? sgl_clash[p] : dbl_clash[p-NS];
            model(cfg_cur[p*6 +: 6], pin, drv, eo, ev, ec);
            if (forced != "")                tag = forced;
            else if (ac != ec)               tag = "R7";
            else if ((av & drv) != 4'b0)     tag = "R10";
            else if (ev == 4'b0)             tag = "R6";
            else                             tag = "R4";
            chk({ac, av, ao} == {ec, ev, eo}, tag, {55'd0, ac, av, ao}, {55'd0, ec, ev, eo});
        end
    endtask

    function automatic logic [CW-1:0] sweep_cfg(input int k);
        logic [CW-1:0] v;
        for (int p = 0; p < NP; p++) v[p*6 +: 6] = 6'((k + p * 5) % 64);
        return v;
    endfunction

    task automatic set_drive(input int d);
        for (int p = 0; p < NP; p++) begin
            logic [3:0] nib;
            nib = 4'((d + p) % 16);
            for (int s = 0; s < 4; s++)
                if (p < NS) sgl_drv[s*NS+p] = nib[s];
                else        dbl_drv[s*ND+p-NS] = nib[s];
        end
    endtask

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] v;
        repeat (3) @(negedge cfg_clk);
        sgl_in  = 32'hDEAD_BEEF;
        sgl_drv = '1;
        dbl_in  = 16'hFFFF;
        dbl_drv = 16'h5A5A;
        rst = 1'b0;
        @(negedge cfg_clk);
        // R1: nothing routes after reset
        chk(sgl_vld == '0 && sgl_out == '0 && dbl_vld == '0 && dbl_out == '0,
            "R1", {sgl_vld, sgl_out}, 64'd0);
        chk(sgl_clash == '0 && dbl_clash == '0, "R1", {52'd0, sgl_clash, dbl_clash}, 64'd0);

        // R11/R12: point 3 N-S only (bit 19); north drives track 3
        v = '0; v[3*6+1] = 1'b1;
        shift_cfg(v); pulse_load(v);
        sgl_drv = '0; dbl_drv = '0;
        sgl_drv[0*NS+3] = 1'b1;
        sgl_in = '0; sgl_in[0*NS+3] = 1'b1;
        #2;
        chk(sgl_vld == (32'd1 << (2*NS+3)) && sgl_out == (32'd1 << (2*NS+3)),
            "R11", {sgl_vld, sgl_out}, {32'd1 << (2*NS+3), 32'd1 << (2*NS+3)});
        chk(sgl_vld[2*NS+2] == 1'b0 && sgl_vld[2*NS+4] == 1'b0, "R12",
            {62'd0, sgl_vld[2*NS+2], sgl_vld[2*NS+4]}, 64'd0);

        // R8: double point 8 E-W (bit 52); single track 0 left open
        v = '0; v[8*6+4] = 1'b1;
        shift_cfg(v); pulse_load(v);
        sgl_drv = '0; sgl_drv[1*NS+0] = 1'b1; sgl_in = '1;
        dbl_drv = '0; dbl_drv[1*ND+0] = 1'b1; dbl_drv[1*ND+1] = 1'b1; dbl_in = '1;
        #2;
        chk(sgl_vld == '0, "R8", {32'd0, sgl_vld}, 64'd0);
        chk(dbl_vld == (16'd1 << (3*ND+0)) && dbl_out == (16'd1 << (3*ND+0)), "R8",
            {32'd0, dbl_vld, dbl_out}, {32'd0, 16'd1 << (3*ND), 16'd1 << (3*ND)});
        compare_all("R8");

        // R5: single track 2 with N-E, N-S, N-W on, north drives 1
        v = '0; v[2*6 +: 6] = 6'b000111;
        shift_cfg(v); pulse_load(v);
        sgl_drv = '0; dbl_drv = '0; sgl_drv[0*NS+2] = 1'b1;
        sgl_in = '0; sgl_in[0*NS+2] = 1'b1;
        #2;
        chk({sgl_vld[1*NS+2], sgl_vld[2*NS+2], sgl_vld[3*NS+2],
             sgl_out[1*NS+2], sgl_out[2*NS+2], sgl_out[3*NS+2]} == 6'b111111, "R5",
            {58'd0, sgl_vld[1*NS+2], sgl_vld[2*NS+2], sgl_vld[3*NS+2],
             sgl_out[1*NS+2], sgl_out[2*NS+2], sgl_out[3*NS+2]}, 64'h3F);

        // R9: double track 3 with N-E and E-S, north drives 1, south receives
        v = '0; v[11*6+0] = 1'b1; v[11*6+3] = 1'b1;
        shift_cfg(v); pulse_load(v);
        sgl_drv = '0; dbl_drv = '0; dbl_drv[0*ND+3] = 1'b1;
        dbl_in = '0; dbl_in[0*ND+3] = 1'b1;
        #2;
        chk(dbl_vld[2*ND+3] && dbl_out[2*ND+3] && !dbl_vld[3*ND+3], "R9",
            {61'd0, dbl_vld[2*ND+3], dbl_out[2*ND+3], dbl_vld[3*ND+3]}, 64'd6);
        // R7: south also drives the same group
        dbl_drv[2*ND+3] = 1'b1;
        #2;
        chk(dbl_clash[3] && dbl_vld[3*ND +: 1] == 1'b0 && dbl_out == '0, "R7",
            {47'd0, dbl_clash[3], dbl_out}, {47'd1, 16'd0});

        // R2: shift a new setting without load, behaviour must stay
        shift_cfg('1);
        #2;
        compare_all("R2");
        // R3: load applies the shifted setting
        pulse_load('1);
        #2;
        compare_all("R3");

        // R4 R6 R7 R10: sweep all 64 settings per point against all drive patterns
        for (int k = 0; k < 64; k++) begin
            v = sweep_cfg(k);
            shift_cfg(v);
            pulse_load(v);
            for (int d = 0; d < 16; d++) begin
                for (int ph = 0; ph < 2; ph++) begin
                    logic [31:0] pat;
                    pat = (32'(k) * 32'h9E3779B1) ^ (32'(d) * 32'h85EBCA6B);
                    if (ph == 1) pat = ~pat;
                    sgl_in = pat;
                    dbl_in = pat[31:16] ^ pat[15:0];
                    set_drive(d);
                    #2;
                    compare_all("");
                end
            end
        end

        // R1: reset in mid-run clears a loaded routing
        @(negedge cfg_clk);
        rst = 1'b1;
        @(negedge cfg_clk);
        rst = 1'b0;
        cfg_cur = '0;
        sgl_drv = 32'h0000_00FF;
        sgl_in  = '1;
        #2;
        chk(sgl_vld == '0 && dbl_vld == '0 && sgl_clash == '0, "R1",
            {sgl_vld, 16'd0, dbl_vld}, 64'd0);
        compare_all("R1");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule